// File: doc/BRIEF.md
# Condition-code masked register writeback

This block sits at the end of an execution pipeline. It merges a four-component instruction result into a destination register value. On the way it can clamp each result component to [0,1]. It then keeps a component only when a static write mask allows it and a dynamic test on a swizzled condition-code register also allows it. Finally it can refresh one of two four-component condition-code registers from the components it actually wrote. Each condition-code component takes one of four states: greater, equal, less, or unordered. Unordered marks a NaN.

Both condition-code registers live inside the block. A program-start pulse sets every component of both registers to equal. The per-component test results are also registered and brought out, so that branch logic can use them.

An integer mode makes the block handle two's-complement address-register results. In that mode the same masking and condition-code rules apply, but saturation is off and no value counts as NaN.

Top module: `cc_writeback`

## Requirements
- R1: After reset, and one cycle after `start_i`, every component of `cc0_o` and `cc1_o` is EQ. With EQ=1 this makes both outputs 8'h55. Component k sits in bits [2k+1:2k], and x is k=0. When `start_i` and `valid_i` are high together, the instruction's condition-code update is dropped, but its register merge still happens.
- R2: In float mode each IEEE-754 single component is classified as follows:
  - a NaN (all-ones exponent, nonzero mantissa) gives UN=3;
  - +0.0 and -0.0 give EQ=1;
  - any other negative value, including -inf, gives LT=2;
  - any other positive value, including denormals and +inf, gives GT=0.
- R3: The test for destination component k uses component `swz_i[2k+1:2k]` of the register chosen by `cc_sel_i` (0 selects CC0, 1 selects CC1). Swizzles may reorder or replicate components.
- R4: `rule_i` picks the test:
  - TR=0 always passes;
  - EQ=1 passes on EQ;
  - NE=2 passes on anything but EQ;
  - LT=3 passes on LT;
  - GE=4 passes on GT or EQ;
  - LE=5 passes on LT or EQ;
  - GT=6 passes on GT;
  - FL=7 never passes.
  UN passes only NE and TR.
- R5: Lane k of `dest_o` (bits [32k+31:32k]) takes the conditioned result only when `wmask_i[k]` and its test both pass. Otherwise it takes `dest_old_i` lane k.
- R6: When `cc_upd_i` is high, only the written components of the register chosen by `cc_tgt_i` (0 selects CC0, 1 selects CC1) get new codes. Unwritten components, the other register, and every register when `cc_upd_i` is low stay unchanged.
- R7: With `sat_i` high in float mode, the following happens before the merge and before condition-code generation:
  - a negative nonzero value becomes +0.0;
  - a value above 1.0, including +inf, becomes 1.0 (32'h3F800000);
  - a NaN and -0.0 pass through unchanged.
- R8: With `int_i` high, each lane is a signed two's-complement integer. Negative values give LT, zero gives EQ and positive values give GT. UN is never produced and saturation has no effect.
- R9: `dest_o` and `test_o` are registered. Bit k of `test_o` is lane k's test result against the condition code as it stood before the instruction. Both outputs update on the clock edge that samples `valid_i` high, and they hold while `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Program start: both condition codes go to all-EQ |
| valid_i | input | 1 | An instruction result is presented this cycle |
| result_i | input | 128 | Result vector, lane k in bits [32k+31:32k] |
| dest_old_i | input | 128 | Old destination register value |
| wmask_i | input | 4 | Static component write mask, bit k for lane k |
| swz_i | input | 8 | Condition-code swizzle, 2 bits per lane |
| rule_i | input | 3 | Condition test rule |
| cc_sel_i | input | 1 | Register tested: 0 CC0, 1 CC1 |
| cc_upd_i | input | 1 | Enable condition-code update |
| cc_tgt_i | input | 1 | Register updated: 0 CC0, 1 CC1 |
| sat_i | input | 1 | Clamp float results to [0,1] |
| int_i | input | 1 | Treat lanes as signed integers |
| dest_o | output | 128 | Merged destination value |
| cc0_o | output | 8 | Condition-code register 0 |
| cc1_o | output | 8 | Condition-code register 1 |
| test_o | output | 4 | Per-lane condition test results |

## Verification
The bench replays a three-step move sequence. The third step is an NE-masked move. A design that treated UN as failing NE, or that refreshed codes on unwritten lanes, would not end with R0=(0,0,NaN,-2) and CC=(EQ,EQ,UN,LT). It also drives the following cases:

- Replicating and reversing swizzles catch a lane-index mixup.
- All eight rules are run against a register holding one component of each state, which exposes any wrong or swapped rule.
- Saturation is checked on NaN, -0.0, +inf and negative inputs. This catches two errors: clamping a NaN to zero, and classifying before the clamp.
- Integer lanes with a NaN-like bit pattern must read GT and not UN.
- A start pulse arrives together with an update. The CC update of that instruction must lose, and CC1 must stay isolated from CC0 writes.

// File: rtl/cc_wb_pkg.sv
package cc_wb_pkg;
  typedef enum logic [1:0] {CC_GT = 2'd0, CC_EQ = 2'd1, CC_LT = 2'd2, CC_UN = 2'd3} cc_e;
  typedef enum logic [2:0] {
    RULE_TR = 3'd0, RULE_EQ = 3'd1, RULE_NE = 3'd2, RULE_LT = 3'd3,
    RULE_GE = 3'd4, RULE_LE = 3'd5, RULE_GT = 3'd6, RULE_FL = 3'd7
  } rule_e;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;
endpackage

// File: rtl/cc_lane_cond.sv
module cc_lane_cond
  import cc_wb_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  parameter int unsigned W  = EW + MW + 1
) (
  input  logic [W-1:0] val_i,
  input  logic         sat_i,
  input  logic         int_i,
  output logic [W-1:0] val_o,
  output cc_e          cc_o
);
  localparam logic [EW-1:0] BIAS = EW'((1 << (EW - 1)) - 1);
  localparam logic [W-1:0]  ONE  = {1'b0, BIAS, {MW{1'b0}}};

  logic in_nan, in_zero, above_one;
  assign in_nan    = (&val_i[W-2 -: EW]) && (|val_i[MW-1:0]);
  assign in_zero   = ~|val_i[W-2:0];
  assign above_one = !val_i[W-1] && (val_i[W-2:0] > ONE[W-2:0]);

  // clamp first, classify the clamped value
  always_comb begin
    val_o = val_i;
    if (sat_i && !int_i && !in_nan) begin
      if (val_i[W-1] && !in_zero) val_o = '0;
      else if (above_one)         val_o = ONE;
    end
  end

  logic out_nan, out_zero;
  assign out_nan  = (&val_o[W-2 -: EW]) && (|val_o[MW-1:0]);
  assign out_zero = ~|val_o[W-2:0];

  always_comb begin
    if (int_i) begin
      if (val_o[W-1])      cc_o = CC_LT;
      else if (~|val_o)    cc_o = CC_EQ;
      else                 cc_o = CC_GT;
    end else if (out_nan)  cc_o = CC_UN;
    else if (out_zero)     cc_o = CC_EQ;
    else if (val_o[W-1])   cc_o = CC_LT;
    else                   cc_o = CC_GT;
  end
endmodule

// File: rtl/cc_lane_test.sv
module cc_lane_test
  import cc_wb_pkg::*;
(
  input  cc_e   cc_i,
  input  rule_e rule_i,
  output logic  pass_o
);
  always_comb begin
    unique case (rule_i)
      RULE_TR: pass_o = 1'b1;
      RULE_EQ: pass_o = (cc_i == CC_EQ);
      RULE_NE: pass_o = (cc_i != CC_EQ);
      RULE_LT: pass_o = (cc_i == CC_LT);
      RULE_GE: pass_o = (cc_i == CC_GT) || (cc_i == CC_EQ);
      RULE_LE: pass_o = (cc_i == CC_LT) || (cc_i == CC_EQ);
      RULE_GT: pass_o = (cc_i == CC_GT);
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_writeback.sv
module cc_writeback
  import cc_wb_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned W = DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       valid_i,
  input  logic [N*W-1:0]             result_i,
  input  logic [N*W-1:0]             dest_old_i,
  input  logic [N-1:0]               wmask_i,
  input  logic [N*$clog2(N)-1:0]     swz_i,
  input  logic [2:0]                 rule_i,
  input  logic                       cc_sel_i,
  input  logic                       cc_upd_i,
  input  logic                       cc_tgt_i,
  input  logic                       sat_i,
  input  logic                       int_i,
  output logic [N*W-1:0]             dest_o,
  output logic [2*N-1:0]             cc0_o,
  output logic [2*N-1:0]             cc1_o,
  output logic [N-1:0]               test_o
);
  localparam int unsigned SW  = $clog2(N);
  localparam int unsigned CCW = 2 * N;
  localparam logic [CCW-1:0] ALL_EQ = {N{2'b01}};

  logic [CCW-1:0] cc0_q, cc1_q, cc0_nxt, cc1_nxt, cc_src;
  logic [N*W-1:0] merged, dest_q;
  logic [N-1:0]   pass, wr, test_q;
  logic           upd0, upd1;

  assign cc_src = cc_sel_i ? cc1_q : cc0_q;
  assign upd0   = valid_i && cc_upd_i && !cc_tgt_i;
  assign upd1   = valid_i && cc_upd_i &&  cc_tgt_i;

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic [SW-1:0] idx;
    logic [1:0]    swz_cc;
    logic [W-1:0]  cond_val;
    cc_e           lane_cc;

    assign idx    = swz_i[k*SW +: SW];
    assign swz_cc = cc_src[2*idx +: 2];

    cc_lane_test u_test (
      .cc_i   (cc_e'(swz_cc)),
      .rule_i (rule_e'(rule_i)),
      .pass_o (pass[k])
    );

    cc_lane_cond #(.EW(EXP_W), .MW(MAN_W), .W(W)) u_cond (
      .val_i (result_i[k*W +: W]),
      .sat_i (sat_i),
      .int_i (int_i),
      .val_o (cond_val),
      .cc_o  (lane_cc)
    );

    assign wr[k]              = wmask_i[k] && pass[k];
    assign merged[k*W +: W]   = wr[k] ? cond_val : dest_old_i[k*W +: W];
    assign cc0_nxt[2*k +: 2]  = (upd0 && wr[k]) ? 2'(lane_cc) : cc0_q[2*k +: 2];
    assign cc1_nxt[2*k +: 2]  = (upd1 && wr[k]) ? 2'(lane_cc) : cc1_q[2*k +: 2];

    assert_keep_old_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wmask_i[k]) |=> dest_o[k*W +: W] == $past(dest_old_i[k*W +: W]));
    assert_cc_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !wr[k]) |=> (cc0_o[2*k +: 2] == $past(cc0_o[2*k +: 2]) &&
                                cc1_o[2*k +: 2] == $past(cc1_o[2*k +: 2])));
    assert_int_no_un_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !start_i && int_i && cc_upd_i && wr[k]) |=>
        (($past(cc_tgt_i) ? cc1_o[2*k +: 2] : cc0_o[2*k +: 2]) != 2'b11));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc0_q  <= ALL_EQ;
      cc1_q  <= ALL_EQ;
      dest_q <= '0;
      test_q <= '0;
    end else begin
      if (start_i) begin
        cc0_q <= ALL_EQ;
        cc1_q <= ALL_EQ;
      end else begin
        cc0_q <= cc0_nxt;
        cc1_q <= cc1_nxt;
      end
      if (valid_i) begin
        dest_q <= merged;
        test_q <= pass;
      end
    end
  end

  assign dest_o = dest_q;
  assign test_o = test_q;
  assign cc0_o  = cc0_q;
  assign cc1_o  = cc1_q;

  assert_start_eq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cc0_o == ALL_EQ && cc1_o == ALL_EQ));
  assert_fl_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rule_i == 3'd7) |=> test_o == '0);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dest_o) && $stable(test_o)));
endmodule

// File: tb/sim_cc_writeback.sv
module sim_cc_writeback;
  localparam logic [1:0] GT = 2'd0, EQ = 2'd1, LT = 2'd2, UN = 2'd3;
  localparam logic [2:0] K_TR = 3'd0, K_EQ = 3'd1, K_NE = 3'd2, K_LT = 3'd3,
                         K_GE = 3'd4, K_LE = 3'd5, K_GT = 3'd6, K_FL = 3'd7;
  localparam logic [7:0] ID = 8'hE4;
  localparam logic [31:0] M2 = 32'hC000_0000, P2 = 32'h4000_0000, QN = 32'h7FC0_0000,
                          ONE = 32'h3F80_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         st = 0, vld = 0, sel = 0, upd = 0, tgt = 0, sat = 0, im = 0;
  logic [127:0] res = '0, old = '0;
  logic [3:0]   msk = '0;
  logic [7:0]   swz = ID;
  logic [2:0]   rul = K_TR;
  logic [127:0] dest;
  logic [7:0]   cc0, cc1;
  logic [3:0]   tst;

  cc_writeback u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .valid_i(vld), .result_i(res),
    .dest_old_i(old), .wmask_i(msk), .swz_i(swz), .rule_i(rul), .cc_sel_i(sel),
    .cc_upd_i(upd), .cc_tgt_i(tgt), .sat_i(sat), .int_i(im),
    .dest_o(dest), .cc0_o(cc0), .cc1_o(cc1), .test_o(tst)
  );

  int checks = 0, fails = 0;

  function automatic logic [127:0] v4(logic [31:0] x, y, z, w);
    return {w, z, y, x};
  endfunction
  function automatic logic [7:0] c4(logic [1:0] x, y, z, w);
    return {w, z, y, x};
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic [127:0] r, o, input logic [3:0] m, input logic [7:0] s,
                    input logic [2:0] ru, input logic cs, cu, ct, sa, in_int);
    @(negedge clk);
    res = r; old = o; msk = m; swz = s; rul = ru;
    sel = cs; upd = cu; tgt = ct; sat = sa; im = in_int; vld = 1'b1;
    @(posedge clk); #1;
    vld = 1'b0; st = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "cc0 reset", 128'(cc0), 128'(8'h55));
    chk("R1", "cc1 reset", 128'(cc1), 128'(8'h55));
    chk("R9", "dest reset", dest, '0);
  endtask

  task automatic t_example;
    logic [127:0] r1;
    r1 = v4(M2, 0, P2, QN);
    op(r1, '0, 4'hF, ID, K_TR, 0, 1, 0, 0, 0);
    chk("R2", "step1 dest", dest, r1);
    chk("R2", "step1 cc0", 128'(cc0), 128'(c4(LT, EQ, GT, UN)));
    op(v4(0, P2, QN, M2), r1, 4'b0111, ID, K_TR, 0, 1, 0, 0, 0);
    chk("R5", "step2 dest", dest, v4(0, P2, QN, QN));
    chk("R6", "step2 cc0", 128'(cc0), 128'(c4(EQ, GT, UN, UN)));
    op(v4(P2, 0, QN, M2), v4(0, P2, QN, QN), 4'hF, ID, K_NE, 0, 1, 0, 0, 0);
    chk("R5", "step3 dest", dest, v4(0, 0, QN, M2));
    chk("R6", "step3 cc0", 128'(cc0), 128'(c4(EQ, EQ, UN, LT)));
    chk("R4", "step3 test", 128'(tst), 128'(4'b1110));
    chk("R6", "cc1 untouched", 128'(cc1), 128'(8'h55));
  endtask

  task automatic t_rules;
    logic [3:0] exp_t [8];
    logic [127:0] keep;
    exp_t = '{4'b1111, 4'b0010, 4'b1101, 4'b0001, 4'b0110, 4'b0011, 4'b0100, 4'b0000};
    keep = v4(32'h11, 32'h22, 32'h33, 32'h44);
    op(v4(M2, 0, P2, QN), '0, 4'hF, ID, K_TR, 0, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      op(v4(ONE, ONE, ONE, ONE), keep, 4'h0, ID, 3'(i), 0, 1, 0, 0, 0);
      chk("R4", $sformatf("rule %0d test", i), 128'(tst), 128'(exp_t[i]));
    end
    chk("R5", "masked dest kept", dest, keep);
    chk("R6", "masked cc0 kept", 128'(cc0), 128'(c4(LT, EQ, GT, UN)));
  endtask

  task automatic t_swizzle;
    op('0, '0, 4'h0, 8'h00, K_LT, 0, 0, 0, 0, 0);
    chk("R3", "replicate x LT", 128'(tst), 128'(4'b1111));
    op('0, '0, 4'h0, 8'hFF, K_NE, 0, 0, 0, 0, 0);
    chk("R3", "replicate w NE", 128'(tst), 128'(4'b1111));
    op('0, '0, 4'h0, 8'hFF, K_LT, 0, 0, 0, 0, 0);
    chk("R3", "replicate w LT", 128'(tst), 128'(4'b0000));
    op(v4(1, 2, 3, 4), v4(5, 6, 7, 8), 4'hF, 8'h1B, K_GE, 0, 0, 0, 0, 0);
    chk("R3", "reverse GE test", 128'(tst), 128'(4'b0110));
    chk("R5", "reverse GE dest", dest, v4(5, 2, 3, 8));
  endtask

  task automatic t_select;
    op(v4(32'hBF80_0000, 0, 32'h4040_0000, 32'h8000_0000), '0, 4'hF, ID, K_EQ, 1, 1, 1, 0, 0);
    chk("R3", "cc1 select dest", dest, v4(32'hBF80_0000, 0, 32'h4040_0000, 32'h8000_0000));
    chk("R6", "cc1 target", 128'(cc1), 128'(c4(LT, EQ, GT, EQ)));
    chk("R6", "cc0 isolated", 128'(cc0), 128'(c4(LT, EQ, GT, UN)));
    op(v4(P2, P2, P2, P2), '0, 4'hF, ID, K_TR, 0, 0, 0, 0, 0);
    chk("R6", "no update dest", dest, v4(P2, P2, P2, P2));
    chk("R6", "no update cc0", 128'(cc0), 128'(c4(LT, EQ, GT, UN)));
  endtask

  task automatic t_sat;
    op(v4(M2, 32'h4020_0000, 32'h3F00_0000, QN), '0, 4'hF, ID, K_TR, 0, 1, 0, 1, 0);
    chk("R7", "sat dest", dest, v4(0, ONE, 32'h3F00_0000, QN));
    chk("R7", "sat cc0", 128'(cc0), 128'(c4(EQ, GT, GT, UN)));
    op(v4(32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000, 32'h1), '0, 4'hF, ID, K_TR, 0, 1, 0, 1, 0);
    chk("R7", "sat edge dest", dest, v4(32'h8000_0000, ONE, 0, 32'h1));
    chk("R7", "sat edge cc0", 128'(cc0), 128'(c4(EQ, GT, EQ, GT)));
  endtask

  task automatic t_classify;
    op(v4(32'hFF80_0000, 32'h1, 32'h7F80_0000, 32'hFFC0_0000), '0, 4'hF, ID, K_TR, 0, 1, 0, 0, 0);
    chk("R2", "inf/denorm/nan cc0", 128'(cc0), 128'(c4(LT, GT, GT, UN)));
    chk("R7", "no sat passthrough", dest, v4(32'hFF80_0000, 32'h1, 32'h7F80_0000, 32'hFFC0_0000));
  endtask

  task automatic t_int;
    op(v4(32'hFFFF_FFFF, 0, 32'd5, QN), '0, 4'hF, ID, K_TR, 0, 1, 1, 1, 1);
    chk("R8", "int dest unclamped", dest, v4(32'hFFFF_FFFF, 0, 32'd5, QN));
    chk("R8", "int cc1", 128'(cc1), 128'(c4(LT, EQ, GT, GT)));
  endtask

  task automatic t_start;
    @(negedge clk); st = 1'b1;
    op(v4(M2, M2, M2, M2), '0, 4'hF, ID, K_TR, 0, 1, 0, 0, 0);
    chk("R1", "start cc0", 128'(cc0), 128'(8'h55));
    chk("R1", "start cc1", 128'(cc1), 128'(8'h55));
    chk("R1", "start merge", dest, v4(M2, M2, M2, M2));
  endtask

  task automatic t_hold;
    logic [127:0] d0;
    logic [3:0] t0;
    d0 = dest; t0 = tst;
    @(negedge clk);
    res = v4(1, 1, 1, 1); old = v4(2, 2, 2, 2); msk = 4'hF; rul = K_FL;
    @(posedge clk); @(posedge clk); #1;
    chk("R9", "hold dest", dest, d0);
    chk("R9", "hold test", 128'(tst), 128'(t0));
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_example();
    t_rules();
    t_swizzle();
    t_select();
    t_sat();
    t_classify();
    t_int();
    t_start();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule